// File: doc/BRIEF.md
# Instruction Mix Counting Analyzer

This block scans a stored program of 32-bit RISC-V machine words, one word per clock, and reports how many instructions of each category it contains. A 2-bit selector picks one of four programs. The block forms a read address from that selector and its own word index, takes the word the instruction store returns in the same cycle, and sorts the word by its opcode. It keeps nine counters: one for every counted word, and one each for register-immediate arithmetic, register-register arithmetic, loads, stores, conditional branches, calls, plain jumps and returns.

Scanning stops at a fixed end-of-program word, 0xC0001073. A program may hold up to 256 words, and that limit includes the end word. When the scan stops, a done flag rises and every counter freezes. A synchronous clear starts a new analysis. An asynchronous active-low reset puts the block into the same idle, zeroed state.

Top module: `imix_analyzer`

## Requirements
- R1: While `rst_n` is low, and on the clock edge after `clr` is sampled high, the word index, all nine counters and `done` are zero. `clr` takes priority over scanning.
- R2: `rd_addr` is `{prog_sel, index}`. The index starts at 0 after a clear and advances by one on each clock edge while the scan is running.
- R3: Opcode field bits [6:0] select the category: 0010011 is register-immediate arithmetic, 0110011 is register-register arithmetic, 0000011 is a load, 0100011 is a store, and 1100011 is a conditional branch.
- R4: Opcode 1101111 with rd (bits [11:7]) equal to zero counts as a plain jump. The same opcode with any nonzero rd counts as a call. Opcode 1100111 always counts as a return.
- R5: `cnt_total` counts every scanned word that is not the end word, including words whose opcode belongs to no category.
- R6: When the word at index m equals 0xC0001073, that word is counted nowhere. `done` goes high on the same edge, which is the (m+1)-th edge after the clear is released.
- R7: Once `done` is high, the counters, `done` and the index hold until the next clear, and a change of `prog_sel` has no effect on them.
- R8: If the 256 words at indices 0 to 255 contain no end word, all 256 are counted and `done` rises on the 256th edge.
- R9: The counters are 9 bits wide and never wrap. `cnt_total` is never smaller than the sum of the eight category counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear; restarts the analysis |
| prog_sel | input | 2 | Selects which stored program is scanned |
| rd_addr | output | 10 | Read address to the instruction store |
| rd_data | input | 32 | Word returned by the store in the same cycle |
| cnt_total | output | 9 | Number of scanned words, end word excluded |
| cnt_alu_imm | output | 9 | Register-immediate arithmetic count |
| cnt_alu_reg | output | 9 | Register-register arithmetic count |
| cnt_load | output | 9 | Load count |
| cnt_store | output | 9 | Store count |
| cnt_branch | output | 9 | Conditional branch count |
| cnt_call | output | 9 | Call count (jal with nonzero rd) |
| cnt_jump | output | 9 | Plain jump count (jal with rd zero) |
| cnt_ret | output | 9 | Return count (jalr) |
| done | output | 1 | Scan finished; counters frozen |

## Verification
The bench builds the block with its default parameters: an 8-bit word index, a 2-bit selector and 9-bit counters. Its memory model therefore holds four full 256-word programs. At these sizes every boundary case is reachable within the run: an end word at index 0, an end word at the last index 255, and a program with no end word that runs the index to its limit and drives the total to 256. Random words cover every opcode category, both values of rd for jal, and opcodes outside all categories.

// File: rtl/imix_pkg.sv
package imix_pkg;
  localparam int WORD_W  = 32;
  localparam int NUM_CAT = 8;

  // category slots of the per-category hit vector
  localparam int CI_ALUI   = 0;
  localparam int CI_ALUR   = 1;
  localparam int CI_LOAD   = 2;
  localparam int CI_STORE  = 3;
  localparam int CI_BRANCH = 4;
  localparam int CI_CALL   = 5;
  localparam int CI_JUMP   = 6;
  localparam int CI_RET    = 7;

  localparam logic [6:0] OP_ALUI   = 7'b0010011;
  localparam logic [6:0] OP_ALUR   = 7'b0110011;
  localparam logic [6:0] OP_LOAD   = 7'b0000011;
  localparam logic [6:0] OP_STORE  = 7'b0100011;
  localparam logic [6:0] OP_BRANCH = 7'b1100011;
  localparam logic [6:0] OP_JAL    = 7'b1101111;
  localparam logic [6:0] OP_JALR   = 7'b1100111;

  localparam logic [WORD_W-1:0] END_WORD = 32'hC000_1073;
endpackage

// File: rtl/imix_classifier.sv
module imix_classifier
  import imix_pkg::*;
(
  input  logic [WORD_W-1:0]  word,
  output logic [NUM_CAT-1:0] hit,
  output logic               is_end
);
  logic [6:0] opcode;
  logic [4:0] rd;

  assign opcode = word[6:0];
  assign rd     = word[11:7];
  assign is_end = (word == END_WORD);

  always_comb begin
    hit = '0;
    case (opcode)
      OP_ALUI:   hit[CI_ALUI]   = 1'b1;
      OP_ALUR:   hit[CI_ALUR]   = 1'b1;
      OP_LOAD:   hit[CI_LOAD]   = 1'b1;
      OP_STORE:  hit[CI_STORE]  = 1'b1;
      OP_BRANCH: hit[CI_BRANCH] = 1'b1;
      OP_JAL: begin
        if (rd == 5'd0) hit[CI_JUMP] = 1'b1;
        else            hit[CI_CALL] = 1'b1;
      end
      OP_JALR:   hit[CI_RET]    = 1'b1;
      default:   hit = '0;
    endcase
  end
endmodule

// File: rtl/imix_counter.sv
module imix_counter #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_nx;
  logic             count_en;

  assign count_en = clr | inc;

  always_comb begin
    if (clr) count_nx = '0;
    else     count_nx = count + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (count_en) count <= count_nx;
  end

  // R9: a counter only moves up between clears
  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (count >= $past(count)));
endmodule

// File: rtl/imix_sequencer.sv
module imix_sequencer #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             end_seen,
  output logic [IDX_W-1:0] idx,
  output logic             done
);
  localparam logic [IDX_W-1:0] IDX_LAST = {IDX_W{1'b1}};

  logic [IDX_W-1:0] idx_nx;
  logic             done_nx;
  logic             seq_en;
  logic             stop;

  assign stop   = end_seen | (idx == IDX_LAST);
  assign seq_en = clr | ~done;

  always_comb begin
    idx_nx  = idx;
    done_nx = done;
    if (clr) begin
      idx_nx  = '0;
      done_nx = 1'b0;
    end else if (stop) begin
      done_nx = 1'b1;
    end else begin
      idx_nx  = idx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      done <= 1'b0;
    end else if (seq_en) begin
      idx  <= idx_nx;
      done <= done_nx;
    end
  end

  // R7: finished state is sticky until cleared
  assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> (done && $stable(idx)));
  // R1: clear returns to index zero, not done
  assert_clear_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (idx == '0 && !done));
endmodule

// File: rtl/imix_analyzer.sv
module imix_analyzer
  import imix_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int SEL_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic [SEL_W-1:0]       prog_sel,
  output logic [SEL_W+IDX_W-1:0] rd_addr,
  input  logic [WORD_W-1:0]      rd_data,
  output logic [IDX_W:0]         cnt_total,
  output logic [IDX_W:0]         cnt_alu_imm,
  output logic [IDX_W:0]         cnt_alu_reg,
  output logic [IDX_W:0]         cnt_load,
  output logic [IDX_W:0]         cnt_store,
  output logic [IDX_W:0]         cnt_branch,
  output logic [IDX_W:0]         cnt_call,
  output logic [IDX_W:0]         cnt_jump,
  output logic [IDX_W:0]         cnt_ret,
  output logic                   done
);
  localparam int CNT_W = IDX_W + 1;
  localparam int SUM_W = CNT_W + $clog2(NUM_CAT) + 1;

  logic [IDX_W-1:0]   idx;
  logic [NUM_CAT-1:0] hit;
  logic               is_end;
  logic               scan_en;
  logic [CNT_W-1:0]   cat_cnt [NUM_CAT];
  logic [SUM_W-1:0]   cat_sum;

  assign rd_addr = {prog_sel, idx};
  assign scan_en = ~clr & ~done & ~is_end;

  imix_classifier u_class (
    .word   (rd_data),
    .hit    (hit),
    .is_end (is_end)
  );

  imix_sequencer #(.IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .end_seen (is_end),
    .idx      (idx),
    .done     (done)
  );

  imix_counter #(.CNT_W(CNT_W)) u_total (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .inc   (scan_en),
    .count (cnt_total)
  );

  for (genvar c = 0; c < NUM_CAT; c++) begin : g_cat
    imix_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .inc   (scan_en & hit[c]),
      .count (cat_cnt[c])
    );
  end

  assign cnt_alu_imm = cat_cnt[CI_ALUI];
  assign cnt_alu_reg = cat_cnt[CI_ALUR];
  assign cnt_load    = cat_cnt[CI_LOAD];
  assign cnt_store   = cat_cnt[CI_STORE];
  assign cnt_branch  = cat_cnt[CI_BRANCH];
  assign cnt_call    = cat_cnt[CI_CALL];
  assign cnt_jump    = cat_cnt[CI_JUMP];
  assign cnt_ret     = cat_cnt[CI_RET];

  always_comb begin
    cat_sum = '0;
    for (int c = 0; c < NUM_CAT; c++) cat_sum = cat_sum + SUM_W'(cat_cnt[c]);
  end

  // R6: the end word stops the scan and is not counted
  assert_end_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !done && rd_data == END_WORD) |=> (done && $stable(cnt_total)));
  // R9: every category hit is also a counted word
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    SUM_W'(cnt_total) >= cat_sum);
  // R1: a clear zeroes the running total
  assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_total == '0 && cat_sum == '0));
  // R7: finished counters stay frozen
  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> ($stable(cnt_total) && $stable(cat_sum)));
endmodule

// File: tb/imix_analyzer_tb_top.sv
module imix_analyzer_tb_top;
  localparam logic [31:0] ENDW = 32'hC000_1073;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clr;
  logic [1:0]  prog_sel;
  logic [9:0]  rd_addr;
  logic [31:0] rd_data;
  logic [8:0]  cnt_total, cnt_alu_imm, cnt_alu_reg, cnt_load, cnt_store;
  logic [8:0]  cnt_branch, cnt_call, cnt_jump, cnt_ret;
  logic        done;
  logic [31:0] mem [0:1023];
  logic [8:0]  act [0:8];

  int nchk = 0;
  int nfail = 0;
  int e [0:8];
  int exp_lat;

  always #4 clk = ~clk;

  assign rd_data = mem[rd_addr];
  assign act[0] = cnt_total;   assign act[1] = cnt_alu_imm; assign act[2] = cnt_alu_reg;
  assign act[3] = cnt_load;    assign act[4] = cnt_store;   assign act[5] = cnt_branch;
  assign act[6] = cnt_call;    assign act[7] = cnt_jump;    assign act[8] = cnt_ret;

  imix_analyzer dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .prog_sel(prog_sel),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .cnt_total(cnt_total), .cnt_alu_imm(cnt_alu_imm), .cnt_alu_reg(cnt_alu_reg),
    .cnt_load(cnt_load), .cnt_store(cnt_store), .cnt_branch(cnt_branch),
    .cnt_call(cnt_call), .cnt_jump(cnt_jump), .cnt_ret(cnt_ret), .done(done)
  );

  task automatic chk(input string req, input int a, input int x);
    nchk++;
    if (a != x) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, a, x);
    end
  endtask

  // slot in e[] for a word: 1..8 by category, 0 when only the total counts
  function automatic int slot_of(input logic [31:0] w);
    case (w[6:0])
      7'b0010011: return 1;
      7'b0110011: return 2;
      7'b0000011: return 3;
      7'b0100011: return 4;
      7'b1100011: return 5;
      7'b1101111: return (w[11:7] != 5'd0) ? 6 : 7;
      7'b1100111: return 8;
      default:    return 0;
    endcase
  endfunction

  function automatic logic [31:0] rand_word();
    logic [31:0] w;
    logic [6:0]  op;
    case ($urandom_range(0, 10))
      0: op = 7'b0010011;  1: op = 7'b0110011;  2: op = 7'b0000011;
      3: op = 7'b0100011;  4: op = 7'b1100011;  5: op = 7'b1101111;
      6: op = 7'b1100111;  7: op = 7'b0110111;  8: op = 7'b0010111;
      9: op = 7'b1110011;  default: op = 7'b0001111;
    endcase
    w = {$urandom() & 32'hFFFF_FF80} | {25'd0, op};
    if (op == 7'b1101111 && $urandom_range(0, 1) == 1) w[11:7] = 5'd0;
    if (w == ENDW) w = w ^ 32'h0010_0000;
    return w;
  endfunction

  task automatic expect_prog(input int p);
    for (int k = 0; k < 9; k++) e[k] = 0;
    exp_lat = 256;
    for (int i = 0; i < 256; i++) begin
      if (mem[p*256 + i] == ENDW) begin
        exp_lat = i + 1;
        break;
      end
      e[0]++;
      if (slot_of(mem[p*256 + i]) != 0) e[slot_of(mem[p*256 + i])]++;
    end
  endtask

  task automatic run_prog(input int p, input string tag);
    int n;
    prog_sel = 2'(p);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R1 total after clear", int'(cnt_total), 0);
    chk("R1 done after clear", int'(done), 0);
    chk("R2 first address", int'(rd_addr), p*256);
    expect_prog(p);
    n = 0;
    while (1) begin
      @(negedge clk);
      n++;
      if (n == 1 && exp_lat > 1) chk("R2 second address", int'(rd_addr), p*256 + 1);
      if (done || n > 300) break;
    end
    chk({tag, " done latency"}, n, exp_lat);
    for (int k = 0; k < 9; k++) chk({tag, " counter"}, int'(act[k]), e[k]);
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    nchk++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    for (int i = 0; i < 1024; i++) mem[i] = rand_word();
    // program 0: directed jal/jalr forms then random words, end at 40
    mem[0] = 32'h0000_006F;  // jal, rd zero: plain jump R4
    mem[1] = 32'h0000_00EF;  // jal, rd one: call R4
    mem[2] = 32'h0000_8067;  // jalr: return R4
    mem[3] = 32'h0001_0537;  // unclassified opcode, total only R5
    mem[40] = ENDW;
    // program 1: end word at index 0 (R6)
    mem[256] = ENDW;
    // program 2: no end word anywhere (R8); random words never equal it
    // program 3: end word at last index 255
    mem[768 + 255] = ENDW;

    rst_n = 1'b0; clr = 1'b0; prog_sel = 2'd0;
    repeat (3) @(negedge clk);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset total", int'(cnt_total), 0);
    chk("R1 reset address", int'(rd_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_prog(0, "R3 R4 R5 R6 prog0");
    // R7: selector change after completion does nothing
    prog_sel = 2'd2;
    repeat (6) @(negedge clk);
    chk("R7 done holds", int'(done), 1);
    for (int k = 0; k < 9; k++) chk("R7 counters hold", int'(act[k]), e[k]);

    run_prog(1, "R6 empty program");
    run_prog(2, "R8 no end word");
    chk("R9 full total", int'(cnt_total), 256);
    run_prog(3, "R6 end at last index");

    // R1: clear in the middle of a scan
    prog_sel = 2'd2;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    repeat (10) @(negedge clk);
    chk("R2 mid-scan total", int'(cnt_total), 10);
    clr = 1'b1;
    @(negedge clk);
    chk("R1 mid-scan clear total", int'(cnt_total), 0);
    chk("R1 mid-scan clear address", int'(rd_addr), 512);
    run_prog(0, "R1 rerun prog0");

    // refill program 1 with random words and a random end position
    for (int i = 0; i < 256; i++) mem[256 + i] = rand_word();
    mem[256 + $urandom_range(1, 254)] = ENDW;
    run_prog(1, "R3 R5 random prog1");

    $display("  %0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule